// File: doc/BRIEF.md
# Enumeration ROM Descriptor Scanner

This block walks a table of 32-bit descriptor words held in an enumeration ROM. It starts at a base address given on an input and fetches one word at a time through a simple synchronous read port. From the words it finds each core on the chip, and for each one it reports the part number, the revision, the register window base and the wrapper window base. Both bases are 4 KB aligned. The walk ends at the end-of-table marker, or at the first malformed entry.

Each core entry is made of a pair of component words. One descriptor then selects which kind of wrapper the core uses. After that comes a run of address descriptors. Some address descriptors are followed by extension words, which the walker steps over without decoding them. A core with no ports is passed over. The block presents each finished core as a record on a valid/ready output and stalls its walk until the record is taken. At the end of a walk it raises a done flag, plus an error flag when the table was malformed.

Top module: `enum_rom_scanner`

## Requirements
- R1: After reset, rom_rd, rec_valid, busy, done and error are all 0.
- R2: A start pulse while idle issues the first read at base_addr. Each later read is at the previous address plus 4, except for a rewind. Each read is a single-cycle rom_rd pulse, and the next pulse follows only after rom_dvalid.
- R3: At the top level, three kinds of word are passed over and the walk goes on: words with bit 0 clear (this includes empty words), address descriptors, and any other type that is not a component or the end marker.
- R4: A component (type field [3:0] = 1) must be followed by a second word of type 1. The record takes the part number from bits [19:8] of the first word and the revision from bits [31:24] of the second. If the second word has any other type, the walk ends with done=1, error=1 and no record.
- R5: If the second component word has a master port count [8:4] of 0 and a slave port count [13:9] of 0, no record is produced and the walk carries on with the next word.
- R6: The word after the component pair selects the wrapper type. A master-port descriptor (type 3) selects slave type 3. An address descriptor (type 5 or 13) selects slave type 2, and that same word is read again as the first address descriptor.
- R7: An address descriptor with bit 3 set (type 13) is followed by one upper-address word. That word is skipped without being decoded, even when it looks like an end marker.
- R8: Only size type 0 in bits [5:4] (4 KB) is matched. Size types 1 and 2 are ignored. Size type 3 causes the next word (a size word) to be skipped, and also the word after it when the size word has bit 3 set.
- R9: A 4 KB address descriptor sets a base only while that base is still zero. Slave type [7:6] = 0 sets the register base, and slave type equal to the selected wrapper type sets the wrapper base. Each base is the descriptor's bits [31:12] followed by 12 zero bits. The record is emitted as soon as both bases are non-zero, and later matches never overwrite a base.
- R10: Two conditions end the walk with done=1 and error=1. One is an end marker (type 15) met while searching for address descriptors. The other is a descriptor after the component pair that is neither a master-port nor an address descriptor.
- R11: An end marker at the top level ends the walk with done=1, error=0 and busy=0.
- R12: While rec_valid is high and rec_ready is low, rec_valid stays high and all record fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| base_addr | input | ADDR_W | Byte address of the first descriptor |
| rom_rd | output | 1 | Read strobe, one cycle per word |
| rom_addr | output | ADDR_W | Byte address of the word being read |
| rom_dvalid | input | 1 | Read data valid |
| rom_data | input | 32 | Descriptor word returned by the ROM |
| rec_valid | output | 1 | Core record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_part | output | 12 | Part number of the core |
| rec_rev | output | 8 | Revision of the core |
| rec_regbase | output | 32 | 4 KB-aligned register window base |
| rec_wrapbase | output | 32 | 4 KB-aligned wrapper window base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (held until the next start) |
| error | output | 1 | Walk ended on a malformed table |

## Verification
The main table mixes the following entries:
- invalid, empty and stray address words at the top level;
- a master-wrapper core whose address run holds 8 KB, 16 KB and explicit-size descriptors, plus upper words that look like end markers;
- a slave-wrapper core whose first address word has to be read twice;
- a portless core;
- a core whose wrapper base is found before its register base.

Together these separate correct skipping, rewinding and first-match capture from designs that decode extension words or overwrite bases. The read-address trace shows whether exactly one rewind took place. Separate short tables set off each error exit and a non-zero start address. Every record is held under back-pressure, so a design that changes fields before the handshake is caught.

// File: rtl/ers_pkg.sv
package ers_pkg;

  localparam int WORD_W   = 32;
  localparam int BASE_LSB = 12;
  localparam int BASE_W   = WORD_W - BASE_LSB;

  localparam logic [3:0] TY_COMP  = 4'h1;
  localparam logic [3:0] TY_MPORT = 4'h3;
  localparam logic [3:0] TY_ADDR  = 4'h5;
  localparam logic [3:0] TY_EOT   = 4'hF;

  localparam logic [1:0] SZ_4K     = 2'd0;
  localparam logic [1:0] SZ_EXPL   = 2'd3;
  localparam logic [1:0] ST_REGS   = 2'd0;
  localparam logic [1:0] ST_WSLAVE = 2'd2;
  localparam logic [1:0] ST_WMAST  = 2'd3;

  typedef enum logic [1:0] {C_IDLE, C_WAIT, C_EMIT} ctrl_t;

  typedef enum logic [2:0] {
    PH_TOP, PH_COMP2, PH_WTYPE, PH_ADDR, PH_AHI, PH_SZ, PH_SZHI
  } phase_t;

  typedef struct packed {
    logic              valid;
    logic              comp;
    logic              mport;
    logic              addr;
    logic              eot;
    logic              upper;
    logic [1:0]        size_t;
    logic [1:0]        slave_t;
    logic [BASE_W-1:0] base;
    logic [11:0]       part;
    logic [7:0]        rev;
    logic [4:0]        n_mp;
    logic [4:0]        n_sp;
  } desc_info_t;

  typedef struct packed {
    logic [11:0]       part;
    logic [7:0]        rev;
    logic [WORD_W-1:0] regbase;
    logic [WORD_W-1:0] wrapbase;
  } core_rec_t;

endpackage

// File: rtl/ers_desc_class.sv
module ers_desc_class
  import ers_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output desc_info_t        info
);
  logic [3:0] ty;
  assign ty = word[3:0];

  always_comb begin
    info.valid   = word[0];
    info.comp    = (ty == TY_COMP);
    info.mport   = (ty == TY_MPORT);
    // bit 3 flags a wide address and is masked off for the address test
    info.addr    = ((ty & 4'b0111) == TY_ADDR);
    info.eot     = (ty == TY_EOT);
    info.upper   = word[3];
    info.size_t  = word[5:4];
    info.slave_t = word[7:6];
    info.base    = word[WORD_W-1:BASE_LSB];
    info.part    = word[19:8];
    info.rev     = word[31:24];
    info.n_mp    = word[8:4];
    info.n_sp    = word[13:9];
  end
endmodule

// File: rtl/ers_addr_match.sv
module ers_addr_match
  import ers_pkg::*;
(
  input  logic [1:0]        size_t,
  input  logic [1:0]        slave_t,
  input  logic [BASE_W-1:0] base,
  input  logic [1:0]        wrap_sel,
  input  logic [BASE_W-1:0] cur_reg,
  input  logic [BASE_W-1:0] cur_wrap,
  output logic              need_size,
  output logic [BASE_W-1:0] new_reg,
  output logic [BASE_W-1:0] new_wrap,
  output logic              both
);
  logic is4k;

  always_comb begin
    need_size = (size_t == SZ_EXPL);
    is4k      = (size_t == SZ_4K);
    new_reg   = (is4k && cur_reg  == '0 && slave_t == ST_REGS)  ? base : cur_reg;
    new_wrap  = (is4k && cur_wrap == '0 && slave_t == wrap_sel) ? base : cur_wrap;
    both      = (new_reg != '0) && (new_wrap != '0);
  end
endmodule

// File: rtl/ers_rec_hold.sv
module ers_rec_hold
  import ers_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  core_rec_t din,
  input  logic      ready,
  output logic      valid,
  output core_rec_t dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/enum_rom_scanner.sv
module enum_rom_scanner
  import ers_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic              rom_dvalid,
  input  logic [WORD_W-1:0] rom_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [11:0]       rec_part,
  output logic [7:0]        rec_rev,
  output logic [WORD_W-1:0] rec_regbase,
  output logic [WORD_W-1:0] rec_wrapbase,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  ctrl_t             ctrl;
  phase_t            phase, nxt_phase;
  logic [ADDR_W-1:0] ptr, nptr;
  logic [11:0]       part_q;
  logic [7:0]        rev_q;
  logic [1:0]        wsel;
  logic [BASE_W-1:0] regb, wrapb;
  logic [1:0]        ad_size, ad_slave;
  logic [BASE_W-1:0] ad_base;

  desc_info_t cur;
  logic       word_in, advance, fin_ok, fin_err, emit_now, do_eval;
  logic       wsel_set, clr_bases;
  logic [1:0] wsel_val;
  logic [1:0]        ev_size, ev_slave;
  logic [BASE_W-1:0] ev_base, mt_reg, mt_wrap;
  logic              mt_need, mt_both;
  core_rec_t         rec_in, rec_out;

  ers_desc_class u_class (.word(rom_data), .info(cur));

  // the word under evaluation is either the incoming word or a held address word
  always_comb begin
    if (phase == PH_AHI) begin
      ev_size = ad_size; ev_slave = ad_slave; ev_base = ad_base;
    end else begin
      ev_size = cur.size_t; ev_slave = cur.slave_t; ev_base = cur.base;
    end
  end

  ers_addr_match u_match (
    .size_t(ev_size), .slave_t(ev_slave), .base(ev_base), .wrap_sel(wsel),
    .cur_reg(regb), .cur_wrap(wrapb),
    .need_size(mt_need), .new_reg(mt_reg), .new_wrap(mt_wrap), .both(mt_both)
  );

  assign word_in = (ctrl == C_WAIT) && rom_dvalid;

  always_comb begin
    nxt_phase = phase;
    advance   = 1'b1;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    do_eval   = 1'b0;
    wsel_set  = 1'b0;
    wsel_val  = ST_WSLAVE;
    clr_bases = 1'b0;
    case (phase)
      PH_TOP: begin
        if (cur.valid && cur.eot)       fin_ok = 1'b1;
        else if (cur.valid && cur.comp) nxt_phase = PH_COMP2;
      end
      PH_COMP2: begin
        if (!cur.comp) fin_err = 1'b1;
        else if (cur.n_mp == '0 && cur.n_sp == '0) nxt_phase = PH_TOP;
        else begin
          nxt_phase = PH_WTYPE;
          clr_bases = 1'b1;
        end
      end
      PH_WTYPE: begin
        if (cur.mport) begin
          nxt_phase = PH_ADDR; wsel_set = 1'b1; wsel_val = ST_WMAST;
        end else if (cur.addr) begin
          nxt_phase = PH_ADDR; wsel_set = 1'b1; wsel_val = ST_WSLAVE;
          advance   = 1'b0;   // read this address word again
        end else fin_err = 1'b1;
      end
      PH_ADDR: begin
        if (cur.eot) fin_err = 1'b1;
        else if (cur.addr) begin
          if (cur.upper) nxt_phase = PH_AHI;
          else           do_eval   = 1'b1;
        end
      end
      PH_AHI:  do_eval = 1'b1;
      PH_SZ:   nxt_phase = cur.upper ? PH_SZHI : PH_ADDR;
      PH_SZHI: nxt_phase = PH_ADDR;
      default: nxt_phase = PH_TOP;
    endcase
    if (do_eval) begin
      if (mt_need)      nxt_phase = PH_SZ;
      else if (mt_both) nxt_phase = PH_TOP;
      else              nxt_phase = PH_ADDR;
    end
  end

  assign emit_now = do_eval && !mt_need && mt_both;
  assign nptr     = advance ? ptr + STEP : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= C_IDLE;
      phase    <= PH_TOP;
      ptr      <= '0;
      rom_rd   <= 1'b0;
      rom_addr <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      part_q   <= '0;
      rev_q    <= '0;
      wsel     <= ST_WSLAVE;
      regb     <= '0;
      wrapb    <= '0;
      ad_size  <= '0;
      ad_slave <= '0;
      ad_base  <= '0;
    end else begin
      case (ctrl)
        C_IDLE: begin
          if (start) begin
            ctrl     <= C_WAIT;
            phase    <= PH_TOP;
            ptr      <= base_addr;
            rom_addr <= base_addr;
            rom_rd   <= 1'b1;
            busy     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
          end
        end
        C_WAIT: begin
          rom_rd <= 1'b0;
          if (word_in) begin
            phase <= nxt_phase;
            ptr   <= nptr;
            if (phase == PH_TOP)   part_q <= cur.part;
            if (phase == PH_COMP2) rev_q  <= cur.rev;
            if (wsel_set)          wsel   <= wsel_val;
            if (clr_bases) begin
              regb  <= '0;
              wrapb <= '0;
            end else if (do_eval) begin
              regb  <= mt_reg;
              wrapb <= mt_wrap;
            end
            if (phase == PH_ADDR) begin
              ad_size  <= cur.size_t;
              ad_slave <= cur.slave_t;
              ad_base  <= cur.base;
            end
            if (fin_ok || fin_err) begin
              ctrl  <= C_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              error <= fin_err;
            end else if (emit_now) begin
              ctrl <= C_EMIT;
            end else begin
              rom_rd   <= 1'b1;
              rom_addr <= nptr;
            end
          end
        end
        C_EMIT: begin
          if (rec_valid && rec_ready) begin
            ctrl     <= C_WAIT;
            rom_rd   <= 1'b1;
            rom_addr <= ptr;
          end
        end
        default: ctrl <= C_IDLE;
      endcase
    end
  end

  assign rec_in = '{part: part_q, rev: rev_q,
                    regbase:  {mt_reg,  {BASE_LSB{1'b0}}},
                    wrapbase: {mt_wrap, {BASE_LSB{1'b0}}}};

  ers_rec_hold u_hold (
    .clk(clk), .rst(rst), .load(word_in && emit_now), .din(rec_in),
    .ready(rec_ready), .valid(rec_valid), .dout(rec_out)
  );

  assign rec_part     = rec_out.part;
  assign rec_rev      = rec_out.rev;
  assign rec_regbase  = rec_out.regbase;
  assign rec_wrapbase = rec_out.wrapbase;
endmodule

// File: rtl/enum_rom_scanner_chk.sv
module enum_rom_scanner_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rom_rd,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [11:0]       rec_part,
  input logic [7:0]        rec_rev,
  input logic [31:0]       rec_regbase,
  input logic [31:0]       rec_wrapbase,
  input logic              busy,
  input logic              done,
  input logic              error
);
  // R2: each read strobe lasts exactly one cycle
  a_r2_rd_single: assert property (@(posedge clk) disable iff (rst)
    rom_rd |=> !rom_rd);

  // R1: no reads are issued while no walk is running
  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rom_rd);

  // R12: a pending record holds until accepted
  a_r12_rec_hold: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_part) && $stable(rec_rev)
                                   && $stable(rec_regbase) && $stable(rec_wrapbase)));

  // R9: offered bases are aligned and both non-zero
  a_r9_bases_aligned: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_regbase[11:0] == 12'h0 && rec_wrapbase[11:0] == 12'h0
                   && rec_regbase != 32'h0 && rec_wrapbase != 32'h0));

  // R11: a finished walk is no longer busy
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: an error is only ever reported with done
  a_r10_error_with_done: assert property (@(posedge clk) disable iff (rst)
    error |-> done);
endmodule

bind enum_rom_scanner enum_rom_scanner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rom_rd(rom_rd), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_part(rec_part), .rec_rev(rec_rev), .rec_regbase(rec_regbase),
  .rec_wrapbase(rec_wrapbase), .busy(busy), .done(done), .error(error)
);

// File: tb/test_enum_rom_scanner.sv
`timescale 1ns/1ps
module test_enum_rom_scanner;
  localparam int AW = 16;

  function automatic logic [31:0] w_c1(input logic [11:0] p);
    return {12'h4BF, p, 4'h0, 4'h1};
  endfunction
  function automatic logic [31:0] w_c2(input logic [7:0] r, input logic [4:0] nmp, input logic [4:0] nsp);
    return {r, 5'd0, 5'd0, nsp, nmp, 4'h1};
  endfunction
  function automatic logic [31:0] w_ad(input logic [19:0] b, input logic [1:0] st,
                                       input logic [1:0] sz, input logic hi);
    return {b, 4'h0, st, sz, hi, 3'b101};
  endfunction
  function automatic logic [31:0] w_mp(input logic [3:0] n);
    return {24'h0, n, 4'h3};
  endfunction

  localparam logic [31:0] EOTW = 32'h0000_000F;
  localparam int NMAIN = 33;
  localparam logic [31:0] IMG [0:NMAIN-1] = '{
    32'h0, 32'h0000_0010, w_ad(20'h1F000, 2'd0, 2'd0, 1'b0),
    w_c1(12'h800), w_c2(8'h11, 5'd1, 5'd1), w_mp(4'd0),
    w_ad(20'h18000, 2'd0, 2'd0, 1'b0), w_ad(20'h18100, 2'd3, 2'd1, 1'b0),
    w_ad(20'h18200, 2'd3, 2'd3, 1'b1), 32'hFFFF_FFFF, 32'h0000_300F, 32'hFFFF_FFFF,
    w_ad(20'h18300, 2'd1, 2'd0, 1'b0), w_ad(20'h18400, 2'd0, 2'd0, 1'b0),
    w_ad(20'h18500, 2'd2, 2'd0, 1'b0), w_ad(20'h18600, 2'd3, 2'd0, 1'b1), 32'h0000_0001,
    w_c1(12'h812), w_c2(8'h2A, 5'd0, 5'd2), w_ad(20'h18001, 2'd0, 2'd0, 1'b0),
    w_mp(4'd1), w_ad(20'h18101, 2'd3, 2'd0, 1'b0), w_ad(20'h18201, 2'd2, 2'd0, 1'b0),
    w_c1(12'h999), w_c2(8'h05, 5'd0, 5'd0), w_ad(20'h1F001, 2'd0, 2'd0, 1'b0),
    w_c1(12'h83E), w_c2(8'h07, 5'd1, 5'd0), w_mp(4'd2),
    w_ad(20'h18002, 2'd3, 2'd0, 1'b0), w_ad(20'h18003, 2'd0, 2'd2, 1'b0),
    w_ad(20'h18004, 2'd0, 2'd0, 1'b0), EOTW
  };
  // expected records: {part, rev, regbase, wrapbase}
  localparam logic [83:0] EXP [0:2] = '{
    {12'h800, 8'h11, 32'h1800_0000, 32'h1860_0000},
    {12'h812, 8'h2A, 32'h1800_1000, 32'h1820_1000},
    {12'h83E, 8'h07, 32'h1800_4000, 32'h1800_2000}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rom_dvalid = 1'b0, rec_ready = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] rom_addr;
  logic [31:0] rom_data = '0;
  logic rom_rd, rec_valid, busy, done, error;
  logic [11:0] rec_part;
  logic [7:0]  rec_rev;
  logic [31:0] rec_regbase, rec_wrapbase;

  always #4 clk = ~clk;

  enum_rom_scanner #(.ADDR_W(AW)) i_enum_rom_scanner (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_dvalid(rom_dvalid), .rom_data(rom_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_part(rec_part), .rec_rev(rec_rev),
    .rec_regbase(rec_regbase), .rec_wrapbase(rec_wrapbase),
    .busy(busy), .done(done), .error(error)
  );

  logic [31:0] rom [0:63];
  int total = 0, bad = 0, cyc = 0;
  int rd_n, reps, badstep;
  logic [AW-1:0] prev_a, first_a;
  logic [83:0] got [0:7];
  int nrec;

  // ROM model: one-cycle latency, plus read-address trace
  always @(posedge clk) begin
    rom_dvalid <= 1'b0;
    if (rom_rd) begin
      rom_dvalid <= 1'b1;
      rom_data   <= rom[rom_addr[7:2]];
      if (rd_n == 0) first_a = rom_addr;
      else if (rom_addr == prev_a) reps++;
      else if (rom_addr != prev_a + 16'd4) badstep++;
      prev_a = rom_addr;
      rd_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [83:0] act, input logic [83:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fill_eot();
    for (int i = 0; i < 64; i++) rom[i] = EOTW;
  endtask

  task automatic run_scan(input logic [AW-1:0] b);
    logic [83:0] snap;
    rd_n = 0; reps = 0; badstep = 0; nrec = 0;
    @(negedge clk); base_addr = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) begin
      if (rec_valid) begin
        snap = {rec_part, rec_rev, rec_regbase, rec_wrapbase};
        repeat (3) @(negedge clk);
        // R12: held under back-pressure
        chk(rec_valid && snap == {rec_part, rec_rev, rec_regbase, rec_wrapbase},
            "R12 record stable", {rec_part, rec_rev, rec_regbase, rec_wrapbase}, snap);
        if (nrec < 8) got[nrec] = snap;
        nrec++;
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
      end else @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({rom_rd, rec_valid, busy, done, error} == 5'b0, "R1 reset outputs",
        84'({rom_rd, rec_valid, busy, done, error}), 84'h0);
    rst = 1'b0;
    @(negedge clk);
    chk({rom_rd, busy, done} == 3'b0, "R1 idle after reset", 84'({rom_rd, busy, done}), 84'h0);

    // main table walked against the expected-record table
    fill_eot();
    for (int i = 0; i < NMAIN; i++) rom[i] = IMG[i];
    run_scan(16'h0000);
    chk(nrec == 3, "R5 R3 record count (portless core and stray words skipped)", 84'(nrec), 84'd3);
    for (int i = 0; i < 3; i++)
      chk(got[i] == EXP[i], "R4 R6 R7 R8 R9 record contents", got[i], EXP[i]);
    chk(done && !error && !busy, "R11 clean end", 84'({done, error, busy}), 84'b100);
    chk(reps == 1, "R6 one rewind", 84'(reps), 84'd1);
    chk(badstep == 0 && first_a == 16'h0, "R2 read addresses step by 4", 84'(badstep), 84'd0);
    chk(rd_n == 34, "R7 R8 words read", 84'(rd_n), 84'd34);

    // R4: second component word of wrong type
    fill_eot();
    rom[0] = w_c1(12'h801); rom[1] = w_ad(20'h18000, 2'd0, 2'd0, 1'b0);
    run_scan(16'h0000);
    chk(done && error && nrec == 0, "R4 broken component pair", 84'({done, error, 8'(nrec)}), 84'h300);
    chk(rd_n == 2, "R4 stops at bad word", 84'(rd_n), 84'd2);

    // R10: neither master-port nor address after component pair
    fill_eot();
    rom[0] = w_c1(12'h802); rom[1] = w_c2(8'h01, 5'd1, 5'd1); rom[2] = w_c1(12'h005);
    run_scan(16'h0000);
    chk(done && error && nrec == 0, "R10 bad wrapper selector", 84'({done, error, 8'(nrec)}), 84'h300);

    // R10: end marker while searching address descriptors
    fill_eot();
    rom[0] = w_c1(12'h803); rom[1] = w_c2(8'h01, 5'd1, 5'd1); rom[2] = w_mp(4'd0);
    rom[3] = w_ad(20'h18000, 2'd0, 2'd0, 1'b0); rom[4] = EOTW;
    run_scan(16'h0000);
    chk(done && error && nrec == 0, "R10 end marker in address search", 84'({done, error, 8'(nrec)}), 84'h300);

    // R2: non-zero start address
    fill_eot();
    rom[32] = w_c1(12'h8AA); rom[33] = w_c2(8'h33, 5'd2, 5'd0); rom[34] = w_mp(4'd2);
    rom[35] = w_ad(20'h18A00, 2'd0, 2'd0, 1'b0); rom[36] = w_ad(20'h18A10, 2'd3, 2'd0, 1'b0);
    run_scan(16'h0080);
    chk(first_a == 16'h0080, "R2 first read at base", 84'(first_a), 84'h80);
    chk(nrec == 1 && got[0] == {12'h8AA, 8'h33, 32'h18A0_0000, 32'h18A1_0000},
        "R9 record from offset table", got[0], {12'h8AA, 8'h33, 32'h18A0_0000, 32'h18A1_0000});
    chk(done && !error && rd_n == 6, "R11 offset table end", 84'({done, error, 8'(rd_n)}), 84'h206);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule